// File: doc/BRIEF.md
# PCM Byte Serial Port with Frame-Sync Width Sensing

This block moves one 8-bit PCM sample per frame in each direction over a pair of serial lines. On the send side it loads a parallel byte at the start of a frame and shifts it out most significant bit first on `ser_out`. The companion `ser_oe` output says when an external high-impedance pad should drive the line. On the receive side it shifts serial bits from `ser_in` into a byte. When the eighth bit is in, it presents the byte on `rx_data` with a one-cycle `rx_valid` strobe.

Every input is sampled in the `clk` domain through a synchronizer, and bit-clock edges are found from the synchronized levels. Two frame-sync formats exist. In the short format the sync pulse lasts one bit period and the data starts one bit later. In the long format the sync pulse lasts three or more bit periods and the data starts with the sync pulse itself. The block measures the width of each send-side sync pulse and keeps a format flag that applies to both directions; after reset the flag selects the short format. With `sync_mode` high, the receive side uses the send bit clock and ignores `rx_bitclk`.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, `ser_oe` is 0, `rx_valid` is 0, `rx_data` is 0 and `long_fsync` is 0 (short format).
- R2: In short format, when `tx_fsync` is seen high at a bit-clock falling edge, having been low at the previous falling edge, the next rising edge sets `ser_oe` to 1 and drives bit 7 of `tx_data`, which is captured at that rising edge.
- R3: After the first bit, each of the next seven rising edges drives the next lower bit (bits 6 down to 0). The falling edge after the rising edge that drove bit 0 clears `ser_oe`.
- R4: In long format, the first rising edge at which `tx_fsync` is high, having been low at the previous rising edge, sets `ser_oe` and drives bit 7. Bits 6 to 0 follow on the next seven rising edges, and release happens as in R3.
- R5: In short format, when `rx_fsync` is seen high at a receive falling edge after being low at the previous one, the next eight falling edges sample `ser_in` as bits 7 down to 0.
- R6: In long format, the falling edge at which `rx_fsync` is first seen high samples bit 7, and the next seven falling edges sample bits 6 to 0.
- R7: After the last bit is sampled, `rx_valid` is high for exactly one `clk` cycle. At the same time `rx_data` shows the byte with the first sampled bit as bit 7, and it holds that value until the next byte completes.
- R8: The width of a `tx_fsync` pulse is counted in send falling edges that see it high. The format is decided at the first falling edge that sees it low again: a width of 1 selects short, a width of 3 or more selects long, and a width of 2 leaves the flag unchanged.
- R9: A new receive frame start (R5 or R6 condition) that arrives while a byte is partly received discards the partial bits and restarts, so only the restarted byte is reported.
- R10: With `sync_mode` high, receive timing uses the send bit clock and `rx_bitclk` has no effect. With `sync_mode` low, receive timing uses `rx_bitclk` only, so a still `rx_bitclk` yields no `rx_valid`.
- R11: While `ser_oe` is 0, `ser_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1: receive side uses the send bit clock; static configuration |
| tx_bitclk | input | 1 | Send bit clock |
| rx_bitclk | input | 1 | Receive bit clock, used when `sync_mode` is 0 |
| tx_fsync | input | 1 | Send frame sync; its width also selects the format |
| rx_fsync | input | 1 | Receive frame sync |
| ser_in | input | 1 | Serial receive data |
| tx_data | input | DATA_W | Byte to send, captured at the frame start |
| ser_out | output | 1 | Serial send data |
| ser_oe | output | 1 | Drive enable for the serial send pad |
| rx_data | output | DATA_W | Last completed received byte |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_data` |
| long_fsync | output | 1 | Format flag: 1 long, 0 short |

## Verification
The assertions rely on the bit clocks being much slower than `clk`, so that a rising and a falling edge are never detected in the same cycle. They also rely on frame syncs and serial data changing only near a rising bit-clock edge and staying steady through the following falling edge. Finally, they assume both bit clocks are low while reset is applied. The stimulus holds each bit-clock phase for six `clk` cycles, which is longer than the synchronizer plus the edge register. It changes syncs and data at the same moment as the rising edge and keeps both clocks low during reset. The exhaustive byte sweeps run in both formats.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
  typedef enum logic {
    FS_SHORT = 1'b0,
    FS_LONG  = 1'b1
  } fs_mode_e;
endpackage

// File: rtl/pcm_sync.sv
// Multi-bit level synchronizer: STAGES flops per bit, reset to zero.
module pcm_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pcm_mode_sense.sv
// Measures send frame-sync width in falling bit-clock edges and keeps the format.
module pcm_mode_sense
  import pcm_pkg::*;
#(
  parameter int LONG_MIN = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     bit_fall,
  input  logic     fs,
  output fs_mode_e mode
);
  localparam int CW = $clog2(LONG_MIN + 1);

  logic [CW-1:0] width_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      width_q <= '0;
      mode    <= FS_SHORT;
    end else if (bit_fall) begin
      if (fs) begin
        if (width_q != CW'(LONG_MIN)) width_q <= width_q + 1'b1;
      end else if (width_q != '0) begin
        if (width_q == CW'(1))             mode <= FS_SHORT;
        else if (width_q == CW'(LONG_MIN)) mode <= FS_LONG;
        width_q <= '0;
      end
    end
  end
endmodule

// File: rtl/pcm_tx.sv
// Send shifter: frame start depends on format, bits move on rising edges,
// release on the falling edge after the last bit.
module pcm_tx
  import pcm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_rise,
  input  logic              bit_fall,
  input  logic              fs,
  input  fs_mode_e          mode,
  input  logic [DATA_W-1:0] load_data,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              fs_at_rise, fs_at_fall, armed, active;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  sent;
  logic              start;

  always_comb begin
    start = 1'b0;
    if (bit_rise) begin
      if (mode == FS_LONG) start = fs && !fs_at_rise;
      else                 start = armed;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_at_rise <= 1'b0;
      fs_at_fall <= 1'b0;
      armed      <= 1'b0;
      active     <= 1'b0;
      shreg      <= '0;
      sent       <= '0;
      sdo        <= 1'b0;
      sdo_en     <= 1'b0;
    end else begin
      if (bit_rise) begin
        fs_at_rise <= fs;
        if (start) begin
          sdo    <= load_data[DATA_W-1];
          shreg  <= load_data << 1;
          sdo_en <= 1'b1;
          active <= 1'b1;
          armed  <= 1'b0;
          sent   <= CNT_W'(1);
        end else if (active && sent != CNT_W'(DATA_W)) begin
          sdo   <= shreg[DATA_W-1];
          shreg <= shreg << 1;
          sent  <= sent + 1'b1;
        end
      end
      if (bit_fall) begin
        fs_at_fall <= fs;
        armed      <= (mode == FS_SHORT) && fs && !fs_at_fall;
        if (active && sent == CNT_W'(DATA_W)) begin
          active <= 1'b0;
          sdo_en <= 1'b0;
          sdo    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_rx.sv
// Receive shifter: samples on falling edges, restarts on any new frame start.
module pcm_rx
  import pcm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_fall,
  input  logic              fs,
  input  logic              sdi,
  input  fs_mode_e          mode,
  output logic [DATA_W-1:0] byte_out,
  output logic              byte_stb
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              fs_prev, active;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  got;
  logic              fs_new;
  logic [DATA_W-1:0] next_sh;

  assign fs_new  = fs && !fs_prev;
  assign next_sh = {shreg[DATA_W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (rst) begin
      fs_prev  <= 1'b0;
      active   <= 1'b0;
      shreg    <= '0;
      got      <= '0;
      byte_out <= '0;
      byte_stb <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      if (bit_fall) begin
        fs_prev <= fs;
        if (fs_new && mode == FS_LONG) begin
          shreg  <= next_sh;
          got    <= CNT_W'(1);
          active <= 1'b1;
        end else if (fs_new) begin
          got    <= '0;
          active <= 1'b1;
        end else if (active) begin
          shreg <= next_sh;
          got   <= got + 1'b1;
          if (got == CNT_W'(DATA_W - 1)) begin
            byte_out <= next_sh;
            byte_stb <= 1'b1;
            active   <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
  import pcm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int LONG_MIN    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_mode,
  input  logic              tx_bitclk,
  input  logic              rx_bitclk,
  input  logic              tx_fsync,
  input  logic              rx_fsync,
  input  logic              ser_in,
  input  logic [DATA_W-1:0] tx_data,
  output logic              ser_out,
  output logic              ser_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              long_fsync
);
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw_in, synced;
  logic s_rxclk, s_txclk, s_rxfs, s_txfs, s_din;
  logic txclk_d, rxclk_d;
  logic tx_rise, tx_fall, rxc_fall, rx_fall;
  fs_mode_e mode;

  assign raw_in = {rx_bitclk, tx_bitclk, rx_fsync, tx_fsync, ser_in};

  pcm_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(synced)
  );

  assign {s_rxclk, s_txclk, s_rxfs, s_txfs, s_din} = synced;

  always_ff @(posedge clk) begin
    if (rst) begin
      txclk_d <= 1'b0;
      rxclk_d <= 1'b0;
    end else begin
      txclk_d <= s_txclk;
      rxclk_d <= s_rxclk;
    end
  end

  assign tx_rise  = s_txclk && !txclk_d;
  assign tx_fall  = !s_txclk && txclk_d;
  assign rxc_fall = !s_rxclk && rxclk_d;
  assign rx_fall  = sync_mode ? tx_fall : rxc_fall;

  pcm_mode_sense #(.LONG_MIN(LONG_MIN)) u_mode (
    .clk(clk), .rst(rst), .bit_fall(tx_fall), .fs(s_txfs), .mode(mode)
  );

  assign long_fsync = (mode == FS_LONG);

  pcm_tx #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .bit_rise(tx_rise), .bit_fall(tx_fall),
    .fs(s_txfs), .mode(mode), .load_data(tx_data),
    .sdo(ser_out), .sdo_en(ser_oe)
  );

  pcm_rx #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .bit_fall(rx_fall), .fs(s_rxfs), .sdi(s_din),
    .mode(mode), .byte_out(rx_data), .byte_stb(rx_valid)
  );
endmodule

// File: rtl/pcm_serial_port_sva.sv
module pcm_serial_port_sva (
  input logic clk,
  input logic rst,
  input logic ser_out,
  input logic ser_oe,
  input logic rx_valid,
  input logic long_fsync,
  input logic x_rise,
  input logic x_fall,
  input logic r_fall
);
  assert_oe_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_oe) |-> $past(x_rise));

  assert_release_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_oe) |-> $past(x_fall));

  assert_out_moves_on_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (ser_oe && $past(ser_oe) && !$past(x_rise)) |-> $stable(ser_out));

  assert_valid_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(r_fall));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_mode_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(long_fsync) |-> $past(x_fall));

  assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (rst)
    !ser_oe |-> !ser_out);
endmodule

bind pcm_serial_port pcm_serial_port_sva u_sva (
  .clk(clk), .rst(rst), .ser_out(ser_out), .ser_oe(ser_oe),
  .rx_valid(rx_valid), .long_fsync(long_fsync),
  .x_rise(tx_rise), .x_fall(tx_fall), .r_fall(rx_fall)
);

// File: tb/pcm_serial_port_tb.sv
module pcm_serial_port_tb;
  localparam int HALF = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_mode = 1'b1;
  logic       tx_bitclk = 1'b0, rx_bitclk = 1'b0;
  logic       tx_fsync = 1'b0, rx_fsync = 1'b0, ser_in = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       ser_out, ser_oe, rx_valid, long_fsync;
  logic [7:0] rx_data;

  int n_checks = 0, n_fail = 0;
  int vcount = 0, multi = 0;
  logic [7:0] last_byte = 8'h00;
  logic prev_valid = 1'b0;
  logic oe_r, do_r, oe_f, do_f;

  always #10 clk = ~clk;

  pcm_serial_port u_dut (
    .clk(clk), .rst(rst), .sync_mode(sync_mode), .tx_bitclk(tx_bitclk),
    .rx_bitclk(rx_bitclk), .tx_fsync(tx_fsync), .rx_fsync(rx_fsync),
    .ser_in(ser_in), .tx_data(tx_data), .ser_out(ser_out), .ser_oe(ser_oe),
    .rx_data(rx_data), .rx_valid(rx_valid), .long_fsync(long_fsync)
  );

  always @(posedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        vcount    = vcount + 1;
        last_byte = rx_data;
        if (prev_valid) multi = multi + 1;
      end
      prev_valid = rx_valid;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_period(input logic fx, input logic fr, input logic d, input logic rx_en);
    @(negedge clk);
    tx_bitclk = 1'b1; rx_bitclk = rx_en;
    tx_fsync = fx; rx_fsync = fr; ser_in = d;
    repeat (HALF) @(negedge clk);
    oe_r = ser_oe; do_r = ser_out;
    tx_bitclk = 1'b0; rx_bitclk = 1'b0;
    repeat (HALF) @(negedge clk);
    oe_f = ser_oe; do_f = ser_out;
  endtask

  // One frame; long_m is the format in force when the frame starts.
  task automatic run_frame(input bit long_m, input logic [7:0] txb, input logic [7:0] rxb,
                           input int fs_len, input logic rx_en, input int exp_valid);
    int v0;
    string req;
    v0 = vcount;
    tx_data = txb;
    req = long_m ? "R4" : "R2/R3";
    for (int p = 0; p < 10; p++) begin
      int idx;
      logic d, eb;
      bit on_r, on_f;
      idx  = long_m ? p : p - 1;
      on_r = (idx >= 0 && idx <= 7);
      on_f = (idx >= 0 && idx <= 6);
      d    = on_r ? rxb[7-idx] : 1'b0;
      eb   = on_r ? txb[7-idx] : 1'b0;
      drive_period(p < fs_len, p < fs_len, d, rx_en);
      check(oe_r == on_r, {req, " oe after rise"}, oe_r, on_r);
      check(do_r == eb,   {req, " bit after rise"}, do_r, eb);
      check(oe_f == on_f, "R3 oe after fall", oe_f, on_f);
      if (!oe_f) check(do_f == 1'b0, "R11 quiet", do_f, 0);
      else       check(do_f == eb, "R3 bit held over fall", do_f, eb);
    end
    drive_period(1'b0, 1'b0, 1'b0, rx_en);
    check(vcount - v0 == exp_valid, long_m ? "R6/R7 valid count" : "R5/R7 valid count",
          vcount - v0, exp_valid);
    if (exp_valid == 1)
      check(last_byte == rxb, long_m ? "R6 rx byte" : "R5 rx byte", last_byte, rxb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check(ser_oe == 1'b0, "R1 oe", ser_oe, 0);
    check(rx_valid == 1'b0, "R1 valid", rx_valid, 0);
    check(rx_data == 8'h00, "R1 data", rx_data, 0);
    check(long_fsync == 1'b0, "R1 short default", long_fsync, 0);

    // Short-format sweep over every byte
    for (int b = 0; b < 256; b++) run_frame(1'b0, 8'(b), 8'(b) ^ 8'hA5, 1, 1'b1, 1);
    check(long_fsync == 1'b0, "R8 width 1 stays short", long_fsync, 0);

    // Width 3 pulse: frame runs in short timing, then format turns long (R8)
    run_frame(1'b0, 8'h3C, 8'hC3, 3, 1'b1, 1);
    check(long_fsync == 1'b1, "R8 width 3 selects long", long_fsync, 1);

    // Long-format sweep, widths 3 and 4
    for (int b = 0; b < 256; b++) run_frame(1'b1, 8'(b), ~8'(b), 3 + (b % 2), 1'b1, 1);
    check(long_fsync == 1'b1, "R8 width 4 keeps long", long_fsync, 1);

    // Width 2 leaves the format alone (R8)
    run_frame(1'b1, 8'h81, 8'h18, 2, 1'b1, 1);
    check(long_fsync == 1'b1, "R8 width 2 no change", long_fsync, 1);

    // Width 1 back to short (R8)
    run_frame(1'b1, 8'h5A, 8'hA5, 1, 1'b1, 1);
    check(long_fsync == 1'b0, "R8 width 1 selects short", long_fsync, 0);

    // R9: receive restart mid-byte, short format
    begin
      int v0;
      logic [7:0] rb;
      rb = 8'h96;
      v0 = vcount;
      drive_period(1'b0, 1'b1, 1'b0, 1'b1);
      drive_period(1'b0, 1'b0, 1'b1, 1'b1);
      drive_period(1'b0, 1'b0, 1'b1, 1'b1);
      drive_period(1'b0, 1'b1, 1'b0, 1'b1);
      for (int k = 0; k < 8; k++) drive_period(1'b0, 1'b0, rb[7-k], 1'b1);
      drive_period(1'b0, 1'b0, 1'b0, 1'b1);
      check(vcount - v0 == 1, "R9 one byte after restart", vcount - v0, 1);
      check(last_byte == rb, "R9 restarted byte", last_byte, rb);
      check(ser_oe == 1'b0, "R11 idle send side", ser_oe, 0);
    end

    // R10: clock selection
    sync_mode = 1'b1;
    run_frame(1'b0, 8'hC6, 8'h6C, 1, 1'b0, 1);  // R10 own clock ignored
    sync_mode = 1'b0;
    run_frame(1'b0, 8'h12, 8'hED, 1, 1'b1, 1);  // R10 own clock used
    run_frame(1'b0, 8'h11, 8'h22, 1, 1'b0, 0);  // R10 still own clock: nothing
    check(last_byte == 8'hED, "R10 byte unchanged", last_byte, 8'hED);
    check(rx_data == 8'hED, "R7 rx_data held", rx_data, 8'hED);

    check(multi == 0, "R7 single-cycle strobe", multi, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule